// File: doc/BRIEF.md
# Victim Line Store

This block is a small, fully associative buffer that sits next to a direct-mapped cache. It receives only the lines the main cache throws out when a miss forces a replacement. Every entry can hold any line, so each entry records the complete line address: the main-cache tag joined with its index.

Each main-cache lookup presents the same line address to this store. The store compares it against every entry at once and answers with a hit flag and the line data in that same cycle, so it adds no latency. When the main cache misses and this store hits, the main cache hands over the line it is displacing. That line is written into the entry that hit, which completes an exchange of the two lines. When the main cache misses in both places, the line it discards arrives on the eviction port. It is placed in a free entry if one exists; otherwise it overwrites the entry used least recently.

Top module: `victim_cache`

## Requirements
- R1: `hit` and `hit_data` reflect the state held before the current clock edge and respond combinationally in the same cycle as `lk_valid`. `hit` is never 1 while `lk_valid` is 0.
- R2: A lookup hits when any valid entry stores a line address equal to `lk_addr`. On a hit, `hit_data` carries that entry's line. On a miss, `hit_data` is all zeros.
- R3: While `rst` is high at a clock edge, every entry becomes invalid. No lookup can hit until a line has been inserted.
- R4: When `ev_en` is high and some entry is invalid, the line on `ev_addr`/`ev_data` is written into the lowest-numbered invalid entry, and one more entry becomes valid.
- R5: When `ev_en` is high and all entries are valid, the least recently used entry is overwritten. Entries never become invalid except by reset.
- R6: A lookup hit and an insertion each make the entry involved the most recently used.
- R7: When `sw_en` is high in a cycle whose lookup hits, the entry that hit is overwritten with `sw_addr`/`sw_data`. The old line then no longer hits, the new one does, and no other entry changes.
- R8: When `sw_en` is high in a cycle whose lookup misses, or in which `lk_valid` is 0, it has no effect.
- R9: When an exchange and an eviction fall in the same cycle, the exchange uses the entry that hit. The eviction then picks among the remaining entries: a free entry first, otherwise the least recently used one, counting the hit entry as most recent. Both lines are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | ADDR_W | Line address being looked up |
| hit | output | 1 | Lookup found a valid matching entry |
| hit_data | output | LINE_W | Line held by the matching entry |
| sw_en | input | 1 | Main cache hands back its displaced line for exchange |
| sw_addr | input | ADDR_W | Line address of the displaced main-cache line |
| sw_data | input | LINE_W | Data of the displaced main-cache line |
| ev_en | input | 1 | Main cache discards a line into the store |
| ev_addr | input | ADDR_W | Line address of the discarded line |
| ev_data | input | LINE_W | Data of the discarded line |

## Verification
An exchange on a lookup hit and an insertion of an unrelated discarded line can occur at the same clock edge, and both touch the recency order. Directed cycles raise `sw_en` on a hit together with `ev_en` when the store is full and when it has free entries. The random phase produces the same overlap often, drawing from a small address pool. Each result is judged by later lookups, which must find both new lines, lose the exchanged line, and lose exactly the entry that a timestamp model in the bench names as least recent.

// File: rtl/vc_pkg.sv
package vc_pkg;
    // Default geometry of the victim store
    localparam int VC_ENTRIES = 4;
    localparam int VC_ADDR_W  = 24;
    localparam int VC_LINE_W  = 64;

    // Index width for a store of n entries (at least one bit)
    function automatic int vc_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/vc_tag_match.sv
module vc_tag_match #(
    parameter int N      = vc_pkg::VC_ENTRIES,
    parameter int ADDR_W = vc_pkg::VC_ADDR_W
) (
    input  logic                     en,
    input  logic [ADDR_W-1:0]        key,
    input  logic [N-1:0]             valid,
    input  logic [N-1:0][ADDR_W-1:0] tags,
    output logic [N-1:0]             match
);
    // One comparator per entry, all working in parallel
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = en && valid[i] && (tags[i] == key);
    end
endmodule

// File: rtl/vc_lru.sv
module vc_lru #(
    parameter int N  = vc_pkg::VC_ENTRIES,
    localparam int IW = vc_pkg::vc_idx_w(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    input  logic          ins_en,
    input  logic [N-1:0]  valid,
    output logic [IW-1:0] ins_idx
);
    // rank 0 = most recent, rank N-1 = least recent; ranks form a permutation
    logic [IW-1:0] rank_q [N];
    logic [IW-1:0] rank_a [N];
    logic [IW-1:0] rank_b [N];
    logic          free_found;

    // Step 1: the lookup hit becomes most recent
    always_comb begin
        for (int j = 0; j < N; j++) begin
            rank_a[j] = rank_q[j];
            if (touch_en) begin
                if (IW'(j) == touch_idx)
                    rank_a[j] = '0;
                else if (rank_q[j] < rank_q[touch_idx])
                    rank_a[j] = rank_q[j] + 1'b1;
            end
        end
    end

    // Step 2: choose the insertion slot: lowest free, else oldest
    always_comb begin
        ins_idx    = '0;
        free_found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!valid[i] && !free_found) begin
                ins_idx    = IW'(i);
                free_found = 1'b1;
            end
        end
        if (!free_found) begin
            for (int i = 0; i < N; i++) begin
                if (rank_a[i] == IW'(N - 1))
                    ins_idx = IW'(i);
            end
        end
    end

    // Step 3: the inserted line becomes most recent
    always_comb begin
        for (int j = 0; j < N; j++) begin
            rank_b[j] = rank_a[j];
            if (ins_en) begin
                if (IW'(j) == ins_idx)
                    rank_b[j] = '0;
                else if (rank_a[j] < rank_a[ins_idx])
                    rank_b[j] = rank_a[j] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int j = 0; j < N; j++) begin
            if (rst) rank_q[j] <= IW'(j);
            else     rank_q[j] <= rank_b[j];
        end
    end
endmodule

// File: rtl/vc_store.sv
module vc_store #(
    parameter int N      = vc_pkg::VC_ENTRIES,
    parameter int ADDR_W = vc_pkg::VC_ADDR_W,
    parameter int LINE_W = vc_pkg::VC_LINE_W,
    localparam int IW    = vc_pkg::vc_idx_w(N)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sw_we,
    input  logic [IW-1:0]            sw_idx,
    input  logic [ADDR_W-1:0]        sw_addr,
    input  logic [LINE_W-1:0]        sw_data,
    input  logic                     ins_we,
    input  logic [IW-1:0]            ins_idx,
    input  logic [ADDR_W-1:0]        ins_addr,
    input  logic [LINE_W-1:0]        ins_data,
    output logic [N-1:0]             valid,
    output logic [N-1:0][ADDR_W-1:0] tags,
    output logic [N-1:0][LINE_W-1:0] lines
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LINE_W-1:0] data;
    } line_t;

    line_t ent_q [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic hit_ins;
        logic hit_sw;
        assign hit_ins  = ins_we && (ins_idx == IW'(i));
        assign hit_sw   = sw_we  && (sw_idx  == IW'(i));
        assign tags[i]  = ent_q[i].addr;
        assign lines[i] = ent_q[i].data;

        always_ff @(posedge clk) begin
            if (rst)          valid[i] <= 1'b0;
            else if (hit_ins) valid[i] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (hit_ins)     ent_q[i] <= '{addr: ins_addr, data: ins_data};
            else if (hit_sw) ent_q[i] <= '{addr: sw_addr, data: sw_data};
        end
    end
endmodule

// File: rtl/victim_cache.sv
module victim_cache #(
    parameter int NUM_ENTRIES = vc_pkg::VC_ENTRIES,
    parameter int ADDR_W      = vc_pkg::VC_ADDR_W,
    parameter int LINE_W      = vc_pkg::VC_LINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              hit,
    output logic [LINE_W-1:0] hit_data,
    input  logic              sw_en,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [LINE_W-1:0] sw_data,
    input  logic              ev_en,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [LINE_W-1:0] ev_data
);
    localparam int IW = vc_pkg::vc_idx_w(NUM_ENTRIES);

    logic [NUM_ENTRIES-1:0]             valid_vec;
    logic [NUM_ENTRIES-1:0]             match_vec;
    logic [NUM_ENTRIES-1:0][ADDR_W-1:0] tag_vec;
    logic [NUM_ENTRIES-1:0][LINE_W-1:0] line_vec;
    logic [IW-1:0]                      hit_idx;
    logic [IW-1:0]                      ins_idx;
    logic                               swap_we;

    vc_tag_match #(.N(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_match (
        .en    (lk_valid),
        .key   (lk_addr),
        .valid (valid_vec),
        .tags  (tag_vec),
        .match (match_vec)
    );

    // Encode the one-hot match and select the line
    always_comb begin
        hit_idx  = '0;
        hit_data = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (match_vec[i]) begin
                hit_idx  = IW'(i);
                hit_data = hit_data | line_vec[i];
            end
        end
    end

    assign hit     = |match_vec;
    assign swap_we = sw_en && hit;

    vc_lru #(.N(NUM_ENTRIES)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (hit),
        .touch_idx (hit_idx),
        .ins_en    (ev_en),
        .valid     (valid_vec),
        .ins_idx   (ins_idx)
    );

    vc_store #(.N(NUM_ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .sw_we    (swap_we),
        .sw_idx   (hit_idx),
        .sw_addr  (sw_addr),
        .sw_data  (sw_data),
        .ins_we   (ev_en),
        .ins_idx  (ins_idx),
        .ins_addr (ev_addr),
        .ins_data (ev_data),
        .valid    (valid_vec),
        .tags     (tag_vec),
        .lines    (line_vec)
    );
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
    parameter int N = vc_pkg::VC_ENTRIES
) (
    input logic         clk,
    input logic         rst,
    input logic         lk_valid,
    input logic         hit,
    input logic         sw_en,
    input logic         ev_en,
    input logic [N-1:0] match,
    input logic [N-1:0] valid
);
    AST_HIT_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (rst)
        hit |-> lk_valid);                                                   // R1
    AST_MATCH_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));                                                    // R2
    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid == '0));                                       // R3
    AST_FILL_GROWS: assert property (@(posedge clk) disable iff (rst)
        (ev_en && !(&valid)) |=> ($countones(valid) == $past($countones(valid)) + 1)); // R4
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (&valid) |=> (&valid));                                              // R5
    AST_SWAP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (sw_en && hit && !ev_en) |=> ($countones(valid) == $past($countones(valid)))); // R7
    AST_IDLE_SWAP_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (sw_en && !hit && !ev_en) |=> $stable(valid));                       // R8
endmodule

bind victim_cache vc_checker #(.N(NUM_ENTRIES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lk_valid (lk_valid),
    .hit      (hit),
    .sw_en    (sw_en),
    .ev_en    (ev_en),
    .match    (match_vec),
    .valid    (valid_vec)
);

// File: tb/tb_victim_cache.sv
`timescale 1ns/1ps
module tb_victim_cache;
    localparam int N  = 4;
    localparam int AW = 24;
    localparam int LW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          hit;
    logic [LW-1:0] hit_data;
    logic          sw_en = 1'b0;
    logic [AW-1:0] sw_addr = '0;
    logic [LW-1:0] sw_data = '0;
    logic          ev_en = 1'b0;
    logic [AW-1:0] ev_addr = '0;
    logic [LW-1:0] ev_data = '0;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Model: timestamps for recency, independent of the design's ranks
    bit            m_valid [N];
    logic [AW-1:0] m_addr  [N];
    logic [LW-1:0] m_data  [N];
    int            m_stamp [N];
    int            m_time;

    always #10 clk = ~clk;

    victim_cache #(.NUM_ENTRIES(N), .ADDR_W(AW), .LINE_W(LW)) dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .hit(hit), .hit_data(hit_data), .sw_en(sw_en), .sw_addr(sw_addr),
        .sw_data(sw_data), .ev_en(ev_en), .ev_addr(ev_addr), .ev_data(ev_data)
    );

    function automatic int m_find(input logic [AW-1:0] a);
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_addr[i] == a) return i;
        return -1;
    endfunction

    function automatic int m_pick();
        int v = -1;
        int best;
        for (int i = 0; i < N; i++)
            if (!m_valid[i] && v < 0) v = i;
        if (v >= 0) return v;
        best = 32'h7fffffff;
        for (int i = 0; i < N; i++)
            if (m_stamp[i] < best) begin best = m_stamp[i]; v = i; end
        return v;
    endfunction

    function automatic logic [AW-1:0] pool(input int k);
        return AW'(24'h3A000 + k * 24'h141);
    endfunction

    function automatic logic [LW-1:0] dgen(input logic [AW-1:0] a, input int salt);
        return {a, 8'(salt), 32'h9E37_79B9 ^ 32'(a * 7)};
    endfunction

    task automatic check(input string req, input logic [LW-1:0] act,
                         input logic [LW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle, check combinational answer, then advance the model
    task automatic cyc(input string req, input bit lk, input logic [AW-1:0] la,
                       input bit sw, input logic [AW-1:0] sa, input logic [LW-1:0] sd,
                       input bit ev, input logic [AW-1:0] ea, input logic [LW-1:0] ed);
        int h;
        int v;
        @(negedge clk);
        lk_valid = lk; lk_addr = la;
        sw_en = sw; sw_addr = sa; sw_data = sd;
        ev_en = ev; ev_addr = ea; ev_data = ed;
        #1;
        h = lk ? m_find(la) : -1;
        check(req, LW'(hit), LW'(h >= 0));
        check(req, hit_data, (h >= 0) ? m_data[h] : '0);
        @(posedge clk);
        #1;
        if (h >= 0) begin
            m_time++; m_stamp[h] = m_time;
            if (sw) begin m_addr[h] = sa; m_data[h] = sd; end
        end
        if (ev) begin
            v = m_pick();
            m_time++;
            m_valid[v] = 1; m_addr[v] = ea; m_data[v] = ed; m_stamp[v] = m_time;
        end
    endtask

    task automatic probe(input string req, input logic [AW-1:0] a, input bit exp_hit);
        @(negedge clk);
        lk_valid = 1; lk_addr = a; sw_en = 0; ev_en = 0;
        #1;
        check(req, LW'(hit), LW'(exp_hit));
        lk_valid = 0;
    endtask

    task automatic ins(input logic [AW-1:0] a);
        cyc("R4", 0, '0, 0, '0, '0, 1, a, dgen(a, 1));
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int dummy;
        dummy = $urandom(32'd2024);
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_addr[i] = '0; m_data[i] = '0; m_stamp[i] = 0;
        end
        m_time = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R3: empty after reset
        probe("R3", pool(0), 0);
        // R1: no hit without a lookup request
        cyc("R1", 0, pool(0), 0, '0, '0, 0, '0, '0);

        // R4: fill free slots, then R2 all hit with data
        for (int k = 0; k < N; k++) ins(pool(k));
        for (int k = 0; k < N; k++)
            cyc("R2", 1, pool(k), 0, '0, '0, 0, '0, '0);
        // R6: touch pool(0) so pool(1) becomes least recent
        cyc("R6", 1, pool(0), 0, '0, '0, 0, '0, '0);
        // R5: full insertion drops least recent
        ins(pool(4));
        probe("R5", pool(1), 0);
        probe("R6", pool(0), 1);
        probe("R5", pool(4), 1);

        // R8: exchange request on a miss is ignored
        cyc("R8", 1, pool(9), 1, pool(8), dgen(pool(8), 2), 0, '0, '0);
        probe("R8", pool(8), 0);
        cyc("R8", 0, pool(2), 1, pool(7), dgen(pool(7), 2), 0, '0, '0);
        probe("R8", pool(7), 0);

        // R7: exchange on a hit
        cyc("R7", 1, pool(2), 1, pool(5), dgen(pool(5), 3), 0, '0, '0);
        probe("R7", pool(2), 0);
        cyc("R7", 1, pool(5), 0, '0, '0, 0, '0, '0);
        probe("R7", pool(3), 1);

        // R9: exchange and eviction in the same cycle, store full
        cyc("R9", 1, pool(3), 1, pool(6), dgen(pool(6), 4), 1, pool(7), dgen(pool(7), 4));
        for (int k = 0; k < 10; k++)
            cyc("R9", 1, pool(k), 0, '0, '0, 0, '0, '0);

        // R9 with free entries: reset and overlap on a partly filled store
        @(negedge clk); rst = 1; ev_en = 0; sw_en = 0; lk_valid = 0;
        @(posedge clk); #1; rst = 0;
        for (int i = 0; i < N; i++) m_valid[i] = 0;
        probe("R3", pool(0), 0);
        ins(pool(0)); ins(pool(1));
        cyc("R9", 1, pool(0), 1, pool(2), dgen(pool(2), 5), 1, pool(3), dgen(pool(3), 5));
        for (int k = 0; k < 5; k++)
            cyc("R9", 1, pool(k), 0, '0, '0, 0, '0, '0);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            bit lk, sw, ev;
            logic [AW-1:0] la, sa, ea;
            int h, g;
            lk = ($urandom % 4) != 0;
            la = pool($urandom % 10);
            h  = lk ? m_find(la) : -1;
            sw = (h >= 0) ? (($urandom % 2) == 1) : (($urandom % 8) == 0);
            ev = ($urandom % 3) == 0;
            sa = pool(0); ea = pool(0);
            g = 0;
            do begin sa = pool($urandom % 10); g++; end
            while ((m_find(sa) >= 0 || sa == la) && g < 50);
            if (g >= 50) sw = 0;
            g = 0;
            do begin ea = pool($urandom % 10); g++; end
            while ((m_find(ea) >= 0 || ea == sa || ea == la) && g < 50);
            if (g >= 50) ev = 0;
            cyc("R2", lk, la, sw, sa, dgen(sa, n), ev, ea, dgen(ea, n + 1));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule